// File: doc/BRIEF.md
# Two-wire serial memory target front end

This block lets a two-wire serial bus controller reach a 128K-byte, byte-wide synchronous memory. Bus clock and data are sampled with the system clock. START and STOP are found by watching data change while the bus clock is high. The block answers only to its own target address byte. The upper nibble of that byte is fixed at 1010. The next two bits must match the chip-select strap inputs. Bit 1 carries bit 16 of the memory address.

A write transfer carries two further bytes with memory address bits 15..0, high byte first. These are loaded into a 17-bit current-address latch. Each data byte after them is written into the memory on the same clock that samples its last bit. There is no busy period and no page buffer. A read transfer always starts at the latch value. The block sends bytes for as long as the controller acknowledges them. The latch moves on by one for every data byte, in both directions. A write-protect input blocks all data writes.

The memory port has a one-cycle read latency. The block asserts a read strobe, and the data is expected on the following clock. The block drives SDA only low, through an output enable.

Top module: `i2c_mem_target`

## Requirements
- R1: A target address byte, sent MSB first, is acknowledged (SDA held low during the ninth clock) only when bits 7..4 equal 1010 and bits 3..2 equal `cs_strap[1:0]`. Any other byte is not acknowledged. After such a byte the block drives nothing and writes nothing until the next START.
- R2: When bit 0 of the target address byte is 0 (write), the next two bytes give address bits 15..0, high byte first. Bit 1 of the address byte gives bit 16. All three bytes are acknowledged, and the 17-bit value replaces the current address.
- R3: Each write data byte causes exactly one `mem_we` pulse, on the clock that samples its eighth bit. The pulse carries the current address and the byte. The current address then advances by one, and the byte is acknowledged.
- R4: When bit 0 of the address byte is 1 (read), bit 1 is ignored and the data comes from the current address, MSB first. The current address advances by one after the eighth bit of every byte sent.
- R5: If the controller acknowledges a read byte, the next sequential byte follows. If it does not, the block releases SDA and sends nothing more.
- R6: The current address wraps from 1FFFFh to 00000h, in both writes and reads.
- R7: A START or STOP that arrives before the eighth bit of a write data byte discards that byte. Memory and the current address are left unchanged.
- R8: While `wp` is high, write data bytes are not acknowledged, no `mem_we` is issued and the current address does not advance. Address bytes are still acknowledged.
- R9: A target address byte sent directly after a completed write transfer is acknowledged, so an acknowledge poll always reports ready.
- R10: The current address is zero after reset, and it keeps its value across STOP conditions.
- R11: `sda_oe` is low in reset and changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, pull the data line low |
| cs_strap | input | 2 | Chip-select strap, compared with address byte bits 3..2 |
| wp | input | 1 | Write protect; a high level blocks data writes |
| mem_addr | output | 17 | Memory address, equal to the current-address latch |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | One-cycle read strobe; data is expected on the next clock |
| mem_rdata | input | 8 | Read data from the memory |

## Verification
The memory write and the latch increment fall on the same clock edge. The write must use the old address, and the address must then advance by one. Writes that start at 1FFFEh push this through the wrap point, and each written location is read back afterwards against a bench model of the memory. The same edge is also where write protect has to suppress both actions together. This is judged by a read of the current address after a protected write: it must return the untouched byte at the loaded address.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
   localparam logic [3:0] DEV_TYPE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_END,
      ST_ACK,
      ST_TX,
      ST_TX_ACK
   } tgt_state_t;

   typedef enum logic [1:0] {
      FLD_DEV,
      FLD_AHI,
      FLD_ALO,
      FLD_DATA
   } rx_field_t;
endpackage

// File: rtl/i2c_bus_front.sv
module i2c_bus_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [1:0] raw;
   logic [1:0] line_s;
   logic       scl_s, scl_q, sda_q;

   assign raw = {scl_i, sda_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
      end
      assign line_s[g] = chain[SYNC_STAGES-1];
   end

   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_addr_latch.sv
module i2c_addr_latch #(
   parameter int AW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc,
   output logic [AW-1:0] cur
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cur <= '0;
      else if (load) cur <= load_val;
      else if (inc)  cur <= cur + AW'(1);
   end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
   import i2c_mem_pkg::*;
#(
   parameter int AW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic [1:0]    cs_strap,
   input  logic          wp,
   input  logic [7:0]    mem_rdata,
   output logic          sda_oe,
   output logic          mem_we,
   output logic [7:0]    mem_wdata,
   output logic          mem_re,
   output logic          addr_load,
   output logic [AW-1:0] addr_load_val,
   output logic          addr_inc
);
   tgt_state_t state;
   rx_field_t  field;
   logic [2:0] cnt;
   logic [6:0] rx_sh;
   logic [7:0] tx_sh;
   logic [7:0] ahi_r;
   logic       ack_r, rd_mode, rd_pend, a16_r;

   logic [7:0] rx_byte;
   logic       last_rx, dev_ok, dev_rd, tx_inc, peer_ack;

   assign rx_byte  = {rx_sh, sda_s};
   assign last_rx  = (state == ST_RX) && scl_rise && (cnt == 3'd7);
   assign dev_ok   = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:2] == cs_strap);
   assign dev_rd   = last_rx && (field == FLD_DEV) && dev_ok && rx_byte[0];
   assign tx_inc   = (state == ST_TX) && scl_rise && (cnt == 3'd7);
   assign peer_ack = (state == ST_TX_ACK) && scl_rise && !sda_s;

   assign mem_we        = last_rx && (field == FLD_DATA) && !wp;
   assign mem_wdata     = rx_byte;
   assign mem_re        = dev_rd | peer_ack;
   assign addr_load     = last_rx && (field == FLD_ALO);
   assign addr_load_val = AW'({a16_r, ahi_r, rx_byte});
   assign addr_inc      = mem_we | tx_inc;

   assign sda_oe = (state == ST_ACK) || ((state == ST_TX) && !tx_sh[7]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         field   <= FLD_DEV;
         cnt     <= '0;
         rx_sh   <= '0;
         tx_sh   <= 8'hFF;
         ahi_r   <= '0;
         ack_r   <= 1'b0;
         rd_mode <= 1'b0;
         rd_pend <= 1'b0;
         a16_r   <= 1'b0;
      end else begin
         rd_pend <= mem_re;
         if (rd_pend) tx_sh <= mem_rdata;
         if (start_det) begin
            state <= ST_RX;
            field <= FLD_DEV;
            cnt   <= '0;
         end else if (stop_det) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_RX: if (scl_rise) begin
                  rx_sh <= rx_byte[6:0];
                  cnt   <= cnt + 3'd1;
                  if (cnt == 3'd7) begin
                     state <= ST_RX_END;
                     case (field)
                        FLD_DEV: begin
                           ack_r   <= dev_ok;
                           rd_mode <= rx_byte[0];
                           a16_r   <= rx_byte[1];
                        end
                        FLD_AHI: begin
                           ack_r <= 1'b1;
                           ahi_r <= rx_byte;
                        end
                        FLD_ALO:  ack_r <= 1'b1;
                        FLD_DATA: ack_r <= !wp;
                        default:  ack_r <= 1'b0;
                     endcase
                  end
               end
               ST_RX_END: if (scl_fall) state <= ack_r ? ST_ACK : ST_IDLE;
               ST_ACK: if (scl_fall) begin
                  cnt <= '0;
                  if (rd_mode) begin
                     state <= ST_TX;
                  end else begin
                     state <= ST_RX;
                     field <= (field == FLD_DEV) ? FLD_AHI :
                              (field == FLD_AHI) ? FLD_ALO : FLD_DATA;
                  end
               end
               ST_TX: if (scl_fall) begin
                  if (cnt == 3'd7) begin
                     state <= ST_TX_ACK;
                     cnt   <= '0;
                  end else begin
                     tx_sh <= {tx_sh[6:0], 1'b1};
                     cnt   <= cnt + 3'd1;
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise && sda_s) state <= ST_IDLE;
                  else if (scl_fall)     state <= ST_TX;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
   import i2c_mem_pkg::*;
#(
   parameter int ADDR_W      = 17,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [1:0]        cs_strap,
   input  logic              wp,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   output logic              mem_re,
   input  logic [7:0]        mem_rdata
);
   if (ADDR_W != 17) begin : g_bad_aw
      $error("ADDR_W must be 17: page bit plus two address bytes");
   end

   logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              addr_load, addr_inc;
   logic [ADDR_W-1:0] addr_load_val;

   i2c_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_tgt_ctrl #(.AW(ADDR_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .sda_s         (sda_s),
      .scl_rise      (scl_rise),
      .scl_fall      (scl_fall),
      .start_det     (start_det),
      .stop_det      (stop_det),
      .cs_strap      (cs_strap),
      .wp            (wp),
      .mem_rdata     (mem_rdata),
      .sda_oe        (sda_oe),
      .mem_we        (mem_we),
      .mem_wdata     (mem_wdata),
      .mem_re        (mem_re),
      .addr_load     (addr_load),
      .addr_load_val (addr_load_val),
      .addr_inc      (addr_inc)
   );

   i2c_addr_latch #(.AW(ADDR_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (addr_load),
      .load_val (addr_load_val),
      .inc      (addr_inc),
      .cur      (mem_addr)
   );
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              wp,
   input logic              sda_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic              mem_re
);
   // R8: a protected bus never reaches the memory write strobe
   p_no_write_protected_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wp |-> !mem_we);

   // R3 and R6: a write advances the address by one, modulo the address space
   p_write_advances_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

   // R3: one strobe per byte
   p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R4: read fetches are single-cycle and never coincide with a write
   p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !mem_re);
   p_rw_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   // R11: the data driver moves only while the bus clock is low
   p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .wp       (wp),
   .sda_oe   (sda_oe),
   .mem_addr (mem_addr),
   .mem_we   (mem_we),
   .mem_re   (mem_re)
);

// File: tb/i2c_mem_target_test.sv
`timescale 1ns/1ps
module i2c_mem_target_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        c_scl = 1'b1;
   logic        c_sda = 1'b1;
   logic [1:0]  strap = 2'b10;
   logic        wp = 1'b0;
   logic        sda_oe, mem_we, mem_re;
   logic [16:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic        sda_line;

   always #2.5 clk = ~clk;
   assign sda_line = c_sda & ~sda_oe;

   i2c_mem_target uut (
      .clk(clk), .rst_n(rst_n), .scl_i(c_scl), .sda_i(sda_line), .sda_oe(sda_oe),
      .cs_strap(strap), .wp(wp), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int fails = 0;
   int we_cnt = 0;
   int oe_bad = 0;
   int exp_ptr = 0;
   logic oe_q = 1'b0;
   logic [7:0] sram [int];
   logic [7:0] exp_mem [int];

   function automatic logic [7:0] pat(input int a);
      return 8'(a * 7 + (a >>> 9) + 90);
   endfunction

   function automatic logic [7:0] exp_rd(input int a);
      return exp_mem.exists(a) ? exp_mem[a] : pat(a);
   endfunction

   function automatic logic [7:0] dev(input logic rw, input logic a16);
      return {4'b1010, strap, a16, rw};
   endfunction

   // memory model with one-cycle read latency
   always @(posedge clk) begin
      if (mem_re) mem_rdata <= sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : pat(int'(mem_addr));
      if (mem_we) begin
         sram[int'(mem_addr)] = mem_wdata;
         we_cnt++;
      end
   end

   always @(negedge clk) begin
      if (rst_n && (sda_oe !== oe_q) && c_scl) oe_bad++;
      oe_q = sda_oe;
   end

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold();
      repeat (6) @(negedge clk);
   endtask

   task automatic bus_start();
      c_sda = 1'b1; hold(); c_scl = 1'b1; hold(); c_sda = 1'b0; hold(); c_scl = 1'b0; hold();
   endtask

   task automatic bus_stop();
      c_sda = 1'b0; hold(); c_scl = 1'b1; hold(); c_sda = 1'b1; hold();
   endtask

   task automatic put_bit(input logic b);
      c_sda = b; hold(); c_scl = 1'b1; hold(); hold(); c_scl = 1'b0; hold();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      c_sda = 1'b1; hold(); c_scl = 1'b1; hold(); acked = !sda_line; hold(); c_scl = 1'b0; hold();
   endtask

   task automatic get_byte(input logic ack, output logic [7:0] b);
      c_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hold(); c_scl = 1'b1; hold(); b[i] = sda_line; hold(); c_scl = 1'b0;
      end
      hold(); c_sda = !ack; hold(); c_scl = 1'b1; hold(); hold(); c_scl = 1'b0; hold(); c_sda = 1'b1;
   endtask

   task automatic send_addr(input int addr);
      logic a;
      send_byte(dev(1'b0, addr[16]), a);   chk("R2 addr byte ack", a, 1);
      send_byte(addr[15:8], a);            chk("R2 high byte ack", a, 1);
      send_byte(addr[7:0], a);             chk("R2 low byte ack", a, 1);
      exp_ptr = addr;
   endtask

   task automatic do_write(input int addr, input int n);
      logic a;
      logic [7:0] d;
      bus_start();
      send_addr(addr);
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         send_byte(d, a);
         if (wp) begin
            chk("R8 protected data nack", a, 0);
            break;
         end
         chk("R3 data ack", a, 1);
         exp_mem[exp_ptr] = d;
         exp_ptr = (exp_ptr + 1) & 32'h1FFFF;
      end
      bus_stop();
   endtask

   task automatic do_read(input bit set_addr, input int addr, input int n);
      logic a;
      logic [7:0] d;
      bus_start();
      if (set_addr) begin
         send_addr(addr);
         bus_start();
      end
      send_byte(dev(1'b1, 1'($urandom)), a);
      chk("R4 read address ack", a, 1);
      for (int k = 0; k < n; k++) begin
         get_byte(k < n - 1, d);
         chk("R4 read data", d, exp_rd(exp_ptr));
         exp_ptr = (exp_ptr + 1) & 32'h1FFFF;
      end
      hold();
      chk("R5 released after nack", sda_oe, 0);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
      $finish;
   end

   initial begin
      logic a;
      int w0;
      void'($urandom(32'h5eed1));
      repeat (5) @(negedge clk);
      chk("R11 oe low in reset", sda_oe, 0);
      chk("R3 no write in reset", mem_we, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R10: first read after reset starts at address zero
      do_read(1'b0, 0, 2);

      // R1: wrong chip select and wrong type nibble
      w0 = we_cnt;
      bus_start();
      send_byte({4'b1010, ~strap, 2'b00}, a); chk("R1 strap mismatch nack", a, 0);
      send_byte(8'h00, a);                    chk("R1 ignored after mismatch", a, 0);
      bus_start();
      send_byte({4'b1011, strap, 2'b00}, a);  chk("R1 type mismatch nack", a, 0);
      bus_stop();
      chk("R1 no write after mismatch", we_cnt, w0);

      // R2 R3: sequential write and random read back
      do_write(32'h12345, 5);
      do_read(1'b1, 32'h12345, 5);
      // R10: current address survives STOP
      do_read(1'b0, 0, 2);

      // R6: wrap in write and read
      do_write(32'h1FFFE, 3);
      // R9: poll straight after the write
      bus_start();
      send_byte(dev(1'b0, 1'b0), a);
      chk("R9 poll ack after write", a, 1);
      bus_stop();
      chk("R6 wrapped byte at zero", sram.exists(0) ? int'(sram[0]) : -1, int'(exp_rd(0)));
      do_read(1'b1, 32'h1FFFE, 4);

      // R8: protected write leaves memory and address alone
      wp = 1'b1;
      w0 = we_cnt;
      do_write(32'h00100, 2);
      chk("R8 no write strobe", we_cnt, w0);
      wp = 1'b0;
      do_read(1'b0, 0, 1);

      // R7: partial byte cut by STOP
      w0 = we_cnt;
      bus_start();
      send_addr(32'h00200);
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      bus_stop();
      chk("R7 stop discards partial", we_cnt, w0);
      // R7: partial byte cut by repeated START, then read at unchanged address
      bus_start();
      send_addr(32'h00300);
      for (int i = 0; i < 5; i++) put_bit(1'b0);
      bus_start();
      send_byte(dev(1'b1, 1'b0), a);
      chk("R7 read after abort ack", a, 1);
      begin
         logic [7:0] d;
         get_byte(1'b0, d);
         chk("R7 address unchanged by abort", d, exp_rd(32'h00300));
      end
      bus_stop();
      chk("R7 no write on start abort", we_cnt, w0);

      // random mix
      for (int it = 0; it < 16; it++) begin
         int ad;
         int n;
         ad = int'($urandom & 32'h1FFFF);
         n  = 1 + int'($urandom % 4);
         if ($urandom % 2 == 0) do_write(ad, n);
         else                   do_read(1'b1, ad, n);
      end
      do_read(1'b1, 32'h12345, 3);

      chk("R11 oe changes only with scl low", oe_bad, 0);
      report();
      $finish;
   end
endmodule